// File: doc/BRIEF.md
# Multi-format stereo serial audio receiver

This block turns a three-wire stereo audio stream into parallel sample pairs. The stream consists of a frame clock whose level marks the channel, a serial data line and the bit clock. The bit clock is the block's own clock `clk`, so every rising edge of `clk` is one bit slot, and the frame clock and data are sampled on that edge. A 2-bit format select chooses one of four framings. Whatever the framing, the sample comes out as a 24-bit two's-complement word with its MSB at bit 23. A one-cycle strobe marks each completed left/right pair.

A single shift register and a slot counter serve every framing. A small state machine decides, for each bit slot, whether the slot carries word data, is padding, or belongs to a continuously shifted right-justified word. The states are ST_WAIT (no frame-clock change seen since reset or since the format changed), ST_WORD (data slots of a left-aligned or I2S word are arriving), ST_PAD (the word is full and the remaining slots of the half-frame are dropped) and ST_STREAM (right-justified mode, where every slot is shifted in). The transitions are:
- WAIT→WORD or WAIT→STREAM on the first frame-clock change.
- WORD→PAD when the word length is reached.
- WORD/PAD→WORD, with a capture, on each frame-clock change.
- STREAM→STREAM, with a capture, on each change.
- Any state→WAIT whenever the format input changes.

Top module: `stereo_ser_rx`

## Requirements
- R1: While `rst_n` is low, `left_out` and `right_out` are zero and `valid` is low.
- R2: A half-frame begins at the first bit slot in which the sampled frame clock differs from its value in the previous slot (slot 0). Data is MSB first. With `fmt` = 0, slots 0 to 15 carry a 16-bit word, which is output as {word, 8'h00}. Any slots after slot 15 are ignored.
- R3: With `fmt` = 1, slots 0 to 23 carry a 24-bit word that is output unchanged, and any later slots of the half-frame are ignored.
- R4: With `fmt` = 2, the word is the last 24 slots before the next frame-clock change, with its LSB in the final slot. Earlier slots are ignored.
- R5: With `fmt` = 3, the MSB sits in slot 1. With at least 24 slots per half-frame, a 24-bit word occupies slots 1 to 24, where slot 24 may be slot 0 of the following half-frame, and later slots are ignored. With exactly 16 slots per half-frame, a 16-bit word occupies slots 1 to 15 plus slot 0 of the following half-frame, and is output as {word, 8'h00}.
- R6: With `fmt` = 0, 1 or 2, a high frame clock marks the left channel. With `fmt` = 3, a low frame clock marks the left channel.
- R7: When the right word of a frame is complete, `valid` is high for exactly one cycle, in the cycle after the edge that samples the frame-clock change ending that right word. `left_out` and `right_out` are updated in that same cycle and hold their values until the next strobe.
- R8: After reset, and after any change of `fmt`, the receiver discards all slots until the next frame-clock change. A partially received half-frame never yields a word.
- R9: A strobe is produced only for a right word that was preceded by a left word captured since the last resynchronisation. A right word without such a left word produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; each rising edge is one bit slot |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Framing select: 0 left-aligned 16-bit, 1 left-aligned 24-bit, 2 right-aligned 24-bit, 3 I2S |
| lrck | input | 1 | Frame (channel) clock, sampled on `clk` rising edges |
| sdata | input | 1 | Serial data, sampled on `clk` rising edges |
| left_out | output | 24 | Last complete left sample, MSB-aligned |
| right_out | output | 24 | Last complete right sample, MSB-aligned |
| valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions assume that `lrck`, `sdata` and `fmt` change only between rising edges of `clk`, so that each edge sees a settled level. They also assume that `fmt` stays constant across the frames it governs. The bench drives all three inputs on the falling edge and changes `fmt` only at segment boundaries. Each segment opens with a short dummy half-frame that provides the resynchronising edge and closes with another that terminates the last word. Within those bounds, the data words, the padding slots and the half-frame lengths are drawn from a seeded `$urandom`, and the full-scale and zero values are placed directly at the start of each segment.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        FMT_MSB16 = 2'd0,
        FMT_MSB24 = 2'd1,
        FMT_LSB24 = 2'd2,
        FMT_I2S   = 2'd3
    } srx_fmt_e;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_WORD,
        ST_PAD,
        ST_STREAM
    } srx_state_e;

    typedef enum logic [1:0] {
        SH_HOLD,
        SH_LOAD,
        SH_SHIFT,
        SH_CLEAR
    } srx_shop_e;

endpackage

// File: rtl/srx_frame_track.sv
module srx_frame_track
    import srx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lrck,
    input  srx_fmt_e fmt,
    output logic     lr_prev,
    output logic     frame_edge,
    output logic     fmt_chg
);

    logic     seen_q;
    srx_fmt_e fmt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            lr_prev <= 1'b0;
            fmt_q   <= FMT_MSB16;
        end else begin
            seen_q  <= 1'b1;
            lr_prev <= lrck;
            fmt_q   <= fmt;
        end
    end

    always_comb begin
        frame_edge = seen_q && (lrck != lr_prev);
        fmt_chg    = seen_q && (fmt != fmt_q);
    end

    // R2: a detected change means the stored level flips on the next slot
    assert_edge_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> (lr_prev != $past(lr_prev)));

endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
    import srx_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    localparam int CNT_W  = $clog2(WORD_W + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  srx_fmt_e         fmt,
    input  logic             frame_edge,
    input  logic             fmt_chg,
    output srx_state_e       state,
    output srx_shop_e        sh_op,
    output logic             cap_en,
    output logic             cap_app,
    output logic [CNT_W-1:0] cap_n
);

    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_W);

    srx_state_e       state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] lim;

    always_comb lim = (fmt == FMT_MSB16) ? LIM_SHORT : LIM_LONG;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT, ST_PAD: begin
                if (frame_edge)
                    state_nxt = (fmt == FMT_LSB24) ? ST_STREAM : ST_WORD;
            end
            ST_WORD: begin
                if (frame_edge)
                    state_nxt = (fmt == FMT_LSB24) ? ST_STREAM : ST_WORD;
                else if (CNT_W'(cnt + 1'b1) >= lim)
                    state_nxt = ST_PAD;
            end
            ST_STREAM: state_nxt = ST_STREAM;
        endcase
        if (fmt_chg)
            state_nxt = ST_WAIT;
    end

    // outputs
    always_comb begin
        sh_op   = SH_HOLD;
        cap_en  = 1'b0;
        cap_app = 1'b0;
        cap_n   = cnt;
        cnt_nxt = cnt;
        unique case (state)
            ST_WAIT, ST_WORD, ST_PAD: begin
                if (frame_edge) begin
                    cap_en  = (state != ST_WAIT);
                    cap_app = (state != ST_WAIT) && (fmt == FMT_I2S) && (cnt < lim);
                    unique case (fmt)
                        FMT_I2S:   begin sh_op = SH_CLEAR; cnt_nxt = '0; end
                        FMT_LSB24: begin sh_op = SH_SHIFT; cnt_nxt = '0; end
                        default:   begin sh_op = SH_LOAD;  cnt_nxt = CNT_W'(1); end
                    endcase
                end else if (state == ST_WORD) begin
                    sh_op   = SH_SHIFT;
                    cnt_nxt = CNT_W'(cnt + 1'b1);
                end
            end
            ST_STREAM: begin
                sh_op  = SH_SHIFT;
                cap_n  = LIM_LONG;
                cap_en = frame_edge;
            end
        endcase
        if (fmt_chg) begin
            sh_op   = SH_CLEAR;
            cap_en  = 1'b0;
            cap_app = 1'b0;
            cnt_nxt = '0;
        end
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_LONG);

    assert_resync_on_fmt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_chg |=> state == ST_WAIT);

    assert_stream_only_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !fmt_chg) |-> fmt == FMT_LSB24);

    assert_pad_means_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && !fmt_chg) |-> cnt == lim);

endmodule

// File: rtl/srx_shift.sv
module srx_shift
    import srx_pkg::*;
#(
    parameter int WORD_W  = 24,
    localparam int CNT_W  = $clog2(WORD_W + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  srx_shop_e         sh_op,
    input  logic              sd,
    input  logic              cap_app,
    input  logic [CNT_W-1:0]  cap_n,
    output logic [WORD_W-1:0] aligned
);

    localparam logic [CNT_W:0] W_V = (CNT_W + 1)'(WORD_W);

    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] raw;
    logic [CNT_W:0]    n_eff;
    logic [CNT_W:0]    amt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            unique case (sh_op)
                SH_HOLD:  sh <= sh;
                SH_LOAD:  sh <= {{(WORD_W-1){1'b0}}, sd};
                SH_SHIFT: sh <= {sh[WORD_W-2:0], sd};
                SH_CLEAR: sh <= '0;
            endcase
        end
    end

    always_comb begin
        raw   = cap_app ? {sh[WORD_W-2:0], sd} : sh;
        n_eff = {1'b0, cap_n} + {{CNT_W{1'b0}}, cap_app};
        amt   = (n_eff >= W_V) ? '0 : (W_V - n_eff);
        aligned = raw << amt;
    end

endmodule

// File: rtl/srx_pair.sv
module srx_pair
    import srx_pkg::*;
#(
    parameter int WORD_W = 24
)(
    input  logic              clk,
    input  logic              rst_n,
    input  srx_fmt_e          fmt,
    input  srx_state_e        state,
    input  logic              lr_prev,
    input  logic              cap_en,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              valid
);

    logic [WORD_W-1:0] lhold;
    logic              lhold_vld;
    logic              is_left;

    always_comb is_left = (fmt == FMT_I2S) ? !lr_prev : lr_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lhold     <= '0;
            lhold_vld <= 1'b0;
            left_out  <= '0;
            right_out <= '0;
            valid     <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (state == ST_WAIT) begin
                lhold_vld <= 1'b0;
            end else if (cap_en && is_left) begin
                lhold     <= word;
                lhold_vld <= 1'b1;
            end else if (cap_en && lhold_vld) begin
                left_out  <= lhold;
                right_out <= word;
                valid     <= 1'b1;
                lhold_vld <= 1'b0;
            end
        end
    end

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_strobe_from_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(cap_en));

    assert_left_before_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(lhold_vld));

    assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (valid || ($stable(left_out) && $stable(right_out))));

endmodule

// File: rtl/stereo_ser_rx.sv
module stereo_ser_rx
    import srx_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    localparam int CNT_W  = $clog2(WORD_W + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt,
    input  logic              lrck,
    input  logic              sdata,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              valid
);

    srx_fmt_e          fmt_e;
    srx_state_e        state;
    srx_shop_e         sh_op;
    logic              lr_prev;
    logic              frame_edge;
    logic              fmt_chg;
    logic              cap_en;
    logic              cap_app;
    logic [CNT_W-1:0]  cap_n;
    logic [WORD_W-1:0] word;

    always_comb fmt_e = srx_fmt_e'(fmt);

    srx_frame_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .lrck       (lrck),
        .fmt        (fmt_e),
        .lr_prev    (lr_prev),
        .frame_edge (frame_edge),
        .fmt_chg    (fmt_chg)
    );

    srx_ctrl #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt_e),
        .frame_edge (frame_edge),
        .fmt_chg    (fmt_chg),
        .state      (state),
        .sh_op      (sh_op),
        .cap_en     (cap_en),
        .cap_app    (cap_app),
        .cap_n      (cap_n)
    );

    srx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sh_op   (sh_op),
        .sd      (sdata),
        .cap_app (cap_app),
        .cap_n   (cap_n),
        .aligned (word)
    );

    srx_pair #(.WORD_W(WORD_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt_e),
        .state     (state),
        .lr_prev   (lr_prev),
        .cap_en    (cap_en),
        .word      (word),
        .left_out  (left_out),
        .right_out (right_out),
        .valid     (valid)
    );

    // R1: nothing is presented while reset holds
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!valid && left_out == '0 && right_out == '0));

endmodule

// File: tb/test_stereo_ser_rx.sv
module test_stereo_ser_rx;

    localparam int MAXN = 6000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  fmt;
    logic        lrck;
    logic        sdata;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        valid;

    always #5 clk = ~clk;

    stereo_ser_rx i_stereo_ser_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .lrck      (lrck),
        .sdata     (sdata),
        .left_out  (left_out),
        .right_out (right_out),
        .valid     (valid)
    );

    logic        lr_a  [MAXN];
    logic        sd_a  [MAXN];
    logic [1:0]  fmt_a [MAXN];
    int          p;
    logic [47:0] exp_q [$];
    string       tag_q [$];
    int          n_run, n_fail, n_pairs;
    logic        prev_valid;
    bit          running;

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] shape(input int f, input int h, input logic [23:0] v);
        if (f == 0 || (f == 3 && h < 24)) return {v[23:8], 8'h00};
        return v;
    endfunction

    task automatic add_half(input logic lv, input int len, input int f);
        for (int i = 0; i < len; i++) begin
            lr_a[p]  = lv;
            fmt_a[p] = 2'(f);
            p++;
        end
    endtask

    task automatic place(input int f, input int h, input int b, input logic [23:0] v);
        if (f == 0) begin
            for (int i = 0; i < 16; i++) sd_a[b+i] = v[23-i];
        end else if (f == 1) begin
            for (int i = 0; i < 24; i++) sd_a[b+i] = v[23-i];
        end else if (f == 2) begin
            for (int i = 0; i < 24; i++) sd_a[b+h-24+i] = v[23-i];
        end else begin
            int n;
            n = (h >= 24) ? 24 : 16;
            for (int i = 0; i < n; i++) sd_a[b+1+i] = v[23-i];
        end
    endtask

    task automatic frame(input int f, input int h, input logic [23:0] l, input logic [23:0] r, input string tag);
        logic ll;
        int   b0, b1;
        ll = (f == 3) ? 1'b0 : 1'b1;   // R6 left level per format
        b0 = p; add_half(ll, h, f);
        b1 = p; add_half(!ll, h, f);
        place(f, h, b0, shape(f, h, l));
        place(f, h, b1, shape(f, h, r));
        exp_q.push_back({shape(f, h, l), shape(f, h, r)});
        tag_q.push_back(tag);
    endtask

    task automatic segment(input int f, input int h, input int nfr, input bit lead_left, input string tag);
        logic ll;
        ll = (f == 3) ? 1'b0 : 1'b1;
        if (lead_left) begin
            // R9: a lone right half after resync must give no strobe
            add_half(ll, 8, f);
            add_half(!ll, h, f);
        end else begin
            add_half(!ll, 8, f);   // R8: resync edge only
        end
        frame(f, h, 24'h7FFFFF, 24'h800000, tag);
        frame(f, h, 24'h000000, 24'hFFFFFF, tag);
        for (int k = 2; k < nfr; k++)
            frame(f, h, 24'($urandom), 24'($urandom), tag);
        add_half(ll, 8, f);        // terminates the last right word
    endtask

    // output monitor, away from the rising edge
    always @(negedge clk) begin
        if (running) begin
            if (valid && prev_valid)
                chk(1'b0, "R7 strobe longer than one cycle", 48'd1, 48'd0);
            if (valid) begin
                n_pairs++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8/R9 unexpected strobe", {left_out, right_out}, 48'd0);
                end else begin
                    logic [47:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({left_out, right_out} == e, t, {left_out, right_out}, e);
                end
            end
            prev_valid = valid;
        end
    end

    initial begin
        int seed_init;
        int n_exp;
        n_run = 0; n_fail = 0; n_pairs = 0;
        prev_valid = 1'b0; running = 1'b0;
        seed_init = $urandom(32'h5EED_0A11);
        for (int i = 0; i < MAXN; i++) begin
            sd_a[i]  = 1'($urandom);
            lr_a[i]  = 1'b0;
            fmt_a[i] = 2'd0;
        end
        p = 0;
        segment(0, 16, 6, 1'b0, "R2 fmt0 32-slot frame");
        segment(1, 32, 6, 1'b0, "R3 fmt1 64-slot frame");
        segment(3, 24, 6, 1'b0, "R5/R6 fmt3 48-slot frame");
        segment(2, 32, 6, 1'b0, "R4 fmt2 64-slot frame");
        segment(3, 16, 6, 1'b0, "R5/R6 fmt3 32-slot frame");
        segment(0, 32, 6, 1'b1, "R2/R9 fmt0 64-slot after lone right");
        segment(2, 28, 6, 1'b0, "R4 fmt2 56-slot frame");
        segment(1, 24, 6, 1'b0, "R3 fmt1 48-slot frame");
        segment(3, 32, 6, 1'b0, "R5/R6 fmt3 64-slot frame");
        n_exp = exp_q.size();

        rst_n = 1'b0; fmt = 2'd0; lrck = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(valid == 1'b0, "R1 valid in reset", {47'd0, valid}, 48'd0);
        chk(left_out == 24'd0 && right_out == 24'd0, "R1 outputs in reset",
            {left_out, right_out}, 48'd0);
        rst_n = 1'b1;
        running = 1'b1;
        for (int k = 0; k < p; k++) begin
            lrck  = lr_a[k];
            sdata = sd_a[k];
            fmt   = fmt_a[k];
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
        running = 1'b0;
        chk(n_pairs == n_exp, "R7/R8/R9 strobe count", 48'(n_pairs), 48'(n_exp));
        chk(exp_q.size() == 0, "R7 missing pairs", 48'(exp_q.size()), 48'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule